// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block feeds a MAC transmitter from a circular ring of descriptors held in system memory. Software fills a descriptor with a buffer address and a frame length, sets its active bit, and pulses the transmit-demand input. The block then fetches the descriptor, reads the frame buffer one 32-bit word at a time, and presents the bytes on a valid/ready byte stream with a last-byte marker. It pads short frames with zeros up to the minimum Ethernet frame size. When the frame is done it writes the status word back, with the active bit cleared and a frame-error bit reflecting the MAC's verdict, and it raises a transmit-complete flag.

After one frame the block moves on to the next descriptor by itself. It wraps to the ring base after a descriptor marked as the ring end, and it stops when it meets a descriptor it does not own. The ring position is kept across stops, so the next demand resumes exactly where processing halted. A demand that arrives while the block is busy is remembered. It causes one more poll after the stop, so a descriptor that software activated late is not missed.

Top module: `txring_dma`

## Requirements
- R1: After reset, memReq, byteValid and tcIrq are all low.
- R2: With no transmit demand since reset, the block issues no memory request.
- R3: Descriptors are 16 bytes. The word at offset 0 is status: bit 31 is active (owned by hardware), bit 30 marks ring end, and bit 27 is frame error. Bits 31:16 of the word at offset 4 hold the frame length. The word at offset 8 holds the word-aligned buffer address. The block reads offset 0, then 4, then 8.
- R4: When the status read finds the active bit clear, processing stops with no write. The next demand polls that same descriptor address again.
- R5: A frame of length L ≥ 64 is sent as exactly L bytes. Each buffer word supplies its bytes most significant byte first. byteLast is high only on the final byte.
- R6: A frame with L < 64, including L = 0, is sent as 64 bytes. Bytes past L are zero, and byteLast is high on the 64th byte.
- R7: While byteValid is high and byteReady is low, byteValid, byteData and byteLast hold steady.
- R8: After the last byte is accepted, the block writes the status word back to offset 0. The written value has bit 31 cleared and bit 27 set to the level of macErr during the last-byte handshake. All other bits are unchanged.
- R9: tcIrq rises after each status writeback. Writing tcClr=1 clears it, and a set in the same cycle wins.
- R10: The first demand after reset starts at ringBase. After a descriptor without the ring-end bit, the next one is 16 bytes further on. After a descriptor with the ring-end bit, the next one is at ringBase.
- R11: Consecutive active descriptors are all sent on a single demand.
- R12: A demand that arrives while a run is in progress triggers exactly one extra poll of the stopping descriptor once the run ends.
- R13: A memory request holds its address, write enable and write data until memAck. Every request address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringBase | input | ADDR_W | Byte address of the first descriptor |
| txDemand | input | 1 | One-cycle pulse: software wrote transmit demand |
| tcClr | input | 1 | Write-one-to-clear strobe for the complete flag |
| tcIrq | output | 1 | Transmit-complete status flag |
| memReq | output | 1 | Memory request, held until memAck |
| memWe | output | 1 | Request is a write |
| memAddr | output | ADDR_W | Byte address of the word |
| memWdata | output | 32 | Write data |
| memAck | input | 1 | Request accepted; read data valid this cycle |
| memRdata | input | 32 | Read data |
| byteValid | output | 1 | Byte stream valid |
| byteReady | input | 1 | MAC accepts a byte |
| byteData | output | 8 | Frame byte |
| byteLast | output | 1 | Final byte of the frame |
| macErr | input | 1 | Frame failed; sampled with the last-byte handshake |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit lengths, a 64-byte minimum and 16-byte descriptors. It uses a four-entry ring whose last entry carries the ring-end bit. With these values, wrap-around, padding of zero-length and sub-word frames, frames of exactly 64 bytes, and multi-word frames that end partway through a word all fall within a few hundred cycles. Random memory latency and random byteReady stalls exercise the hold rules on both interfaces.

// File: rtl/txring_pkg.sv
package txring_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RSTAT, ST_RLEN, ST_RBUF, ST_RDATA, ST_SEND, ST_WB
  } state_e;

  typedef enum logic [1:0] {
    SEL_STAT, SEL_LEN, SEL_BUF, SEL_DATA
  } memSel_e;

  typedef struct packed {
    memSel_e memSel;
    logic    startRun;
    logic    ldStat;
    logic    ldLen;
    logic    ldBuf;
    logic    ldWord;
    logic    byteAdv;
    logic    advRing;
    logic    setTc;
  } dpCtl_t;

endpackage

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   txDemand,
  input  logic   memAck,
  input  logic   rdActive,
  input  logic   needWord,
  input  logic   nextNeedWord,
  input  logic   lastByte,
  input  logic   byteReady,
  output logic   memReq,
  output logic   memWe,
  output logic   byteValid,
  output dpCtl_t ctl
);

  state_e state, stateNxt;
  logic   demandPend;
  logic   go;

  assign go = txDemand | demandPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      demandPend <= 1'b0;
    end else begin
      state <= stateNxt;
      if (state == ST_IDLE)
        demandPend <= 1'b0;
      else if (txDemand)
        demandPend <= 1'b1;
    end
  end

  always_comb begin
    stateNxt  = state;
    memReq    = 1'b0;
    memWe     = 1'b0;
    byteValid = 1'b0;
    ctl       = '0;
    ctl.memSel = SEL_STAT;
    case (state)
      ST_IDLE: begin
        if (go) begin
          ctl.startRun = 1'b1;
          stateNxt     = ST_RSTAT;
        end
      end
      ST_RSTAT: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_STAT;
        if (memAck) begin
          ctl.ldStat = 1'b1;
          stateNxt   = rdActive ? ST_RLEN : ST_IDLE;
        end
      end
      ST_RLEN: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_LEN;
        if (memAck) begin
          ctl.ldLen = 1'b1;
          stateNxt  = ST_RBUF;
        end
      end
      ST_RBUF: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_BUF;
        if (memAck) begin
          ctl.ldBuf = 1'b1;
          stateNxt  = needWord ? ST_RDATA : ST_SEND;
        end
      end
      ST_RDATA: begin
        memReq     = 1'b1;
        ctl.memSel = SEL_DATA;
        if (memAck) begin
          ctl.ldWord = 1'b1;
          stateNxt   = ST_SEND;
        end
      end
      ST_SEND: begin
        byteValid = 1'b1;
        if (byteReady) begin
          ctl.byteAdv = 1'b1;
          if (lastByte)          stateNxt = ST_WB;
          else if (nextNeedWord) stateNxt = ST_RDATA;
        end
      end
      ST_WB: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        ctl.memSel = SEL_STAT;
        if (memAck) begin
          ctl.advRing = 1'b1;
          ctl.setTc   = 1'b1;
          stateNxt    = ST_RSTAT;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/txring_datapath.sv
module txring_datapath
  import txring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MIN_FRAME  = 64,
  parameter int DESC_BYTES = 16,
  parameter int ACT_BIT    = 31,
  parameter int END_BIT    = 30,
  parameter int ERR_BIT    = 27
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  dpCtl_t            ctl,
  input  logic [31:0]       memRdata,
  input  logic              macErr,
  input  logic              tcClr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [7:0]        byteData,
  output logic              lastByte,
  output logic              needWord,
  output logic              nextNeedWord,
  output logic              rdActive,
  output logic              tcIrq
);

  localparam logic [LEN_W-1:0]  MIN_LEN  = LEN_W'(MIN_FRAME);
  localparam logic [ADDR_W-1:0] LEN_OFS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] BUF_OFS  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] DESC_INC = ADDR_W'(DESC_BYTES);
  localparam logic [31:0] CLR_MASK = ~((32'd1 << ACT_BIT) | (32'd1 << ERR_BIT));

  logic                posValid;
  logic [ADDR_W-1:0]   descAddr;
  logic [31:0]         statReg;
  logic [LEN_W-1:0]    lenReg;
  logic [ADDR_W-1:2]   bufWord;
  logic [31:0]         wordReg;
  logic [LEN_W-1:0]    byteCnt;
  logic [LEN_W-1:0]    cntNext;
  logic [LEN_W-1:0]    totalLen;
  logic                errLatch;
  logic                tcFlag;
  logic [7:0]          laneByte;

  assign cntNext      = byteCnt + LEN_W'(1);
  assign totalLen     = (lenReg < MIN_LEN) ? MIN_LEN : lenReg;
  assign lastByte     = (byteCnt == totalLen - LEN_W'(1));
  assign needWord     = (byteCnt < lenReg) && (byteCnt[1:0] == 2'b00);
  assign nextNeedWord = (cntNext < lenReg) && (cntNext[1:0] == 2'b00);
  assign rdActive     = memRdata[ACT_BIT];
  assign tcIrq        = tcFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posValid <= 1'b0;
      descAddr <= '0;
      statReg  <= '0;
      lenReg   <= '0;
      bufWord  <= '0;
      wordReg  <= '0;
      byteCnt  <= '0;
      errLatch <= 1'b0;
      tcFlag   <= 1'b0;
    end else begin
      if (ctl.startRun && !posValid) begin
        descAddr <= ringBase;
        posValid <= 1'b1;
      end
      if (ctl.ldStat) begin
        statReg  <= memRdata;
        errLatch <= 1'b0;
      end
      if (ctl.ldLen) begin
        lenReg  <= memRdata[31 -: LEN_W];
        byteCnt <= '0;
      end
      if (ctl.ldBuf)  bufWord <= memRdata[ADDR_W-1:2];
      if (ctl.ldWord) wordReg <= memRdata;
      if (ctl.byteAdv) begin
        byteCnt <= cntNext;
        if (lastByte) errLatch <= macErr;
      end
      if (ctl.advRing)
        descAddr <= statReg[END_BIT] ? ringBase : descAddr + DESC_INC;
      if (ctl.setTc)      tcFlag <= 1'b1;
      else if (tcClr)     tcFlag <= 1'b0;
    end
  end

  always_comb begin
    case (ctl.memSel)
      SEL_STAT: memAddr = descAddr;
      SEL_LEN:  memAddr = descAddr + LEN_OFS;
      SEL_BUF:  memAddr = descAddr + BUF_OFS;
      default:  memAddr = {bufWord + (ADDR_W-2)'(byteCnt[LEN_W-1:2]), 2'b00};
    endcase
  end

  assign memWdata = (statReg & CLR_MASK) | (32'(errLatch) << ERR_BIT);

  always_comb begin
    case (byteCnt[1:0])
      2'd0:    laneByte = wordReg[31:24];
      2'd1:    laneByte = wordReg[23:16];
      2'd2:    laneByte = wordReg[15:8];
      default: laneByte = wordReg[7:0];
    endcase
  end

  assign byteData = (byteCnt < lenReg) ? laneByte : 8'h00;

endmodule

// File: rtl/txring_dma.sv
module txring_dma
  import txring_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MIN_FRAME  = 64,
  parameter int DESC_BYTES = 16,
  parameter int ACT_BIT    = 31,
  parameter int END_BIT    = 30,
  parameter int ERR_BIT    = 27
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ringBase,
  input  logic              txDemand,
  input  logic              tcClr,
  output logic              tcIrq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic              memAck,
  input  logic [31:0]       memRdata,
  output logic              byteValid,
  input  logic              byteReady,
  output logic [7:0]        byteData,
  output logic              byteLast,
  input  logic              macErr
);

  dpCtl_t ctl;
  logic   rdActive, needWord, nextNeedWord, lastByte;

  txring_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txDemand(txDemand), .memAck(memAck),
    .rdActive(rdActive), .needWord(needWord), .nextNeedWord(nextNeedWord),
    .lastByte(lastByte), .byteReady(byteReady),
    .memReq(memReq), .memWe(memWe), .byteValid(byteValid), .ctl(ctl)
  );

  txring_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME),
    .DESC_BYTES(DESC_BYTES), .ACT_BIT(ACT_BIT), .END_BIT(END_BIT), .ERR_BIT(ERR_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .ctl(ctl),
    .memRdata(memRdata), .macErr(macErr), .tcClr(tcClr),
    .memAddr(memAddr), .memWdata(memWdata), .byteData(byteData),
    .lastByte(lastByte), .needWord(needWord), .nextNeedWord(nextNeedWord),
    .rdActive(rdActive), .tcIrq(tcIrq)
  );

  assign byteLast = byteValid & lastByte;

endmodule

// File: rtl/txring_checker.sv
module txring_checker #(
  parameter int ADDR_W    = 32,
  parameter int MIN_FRAME = 64,
  parameter int ACT_BIT   = 31
)(
  input logic              clk,
  input logic              rstN,
  input logic              tcIrq,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              memAck,
  input logic              byteValid,
  input logic              byteReady,
  input logic [7:0]        byteData,
  input logic              byteLast
);

  logic [31:0] beatCnt;

  always_ff @(posedge clk) begin
    if (!rstN) beatCnt <= '0;
    else if (byteValid && byteReady) beatCnt <= byteLast ? '0 : beatCnt + 32'd1;
  end

  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  a_r13_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00);

  a_r7_byte_hold: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && !byteReady |=> byteValid && $stable(byteData) && $stable(byteLast));

  a_r8_owner_released: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !memWdata[ACT_BIT]);

  a_r9_tc_after_wb: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tcIrq) |-> $past(memReq && memWe && memAck));

  a_r6_min_frame: assert property (@(posedge clk) disable iff (!rstN)
    byteValid && byteReady && byteLast |-> beatCnt >= 32'(MIN_FRAME - 1));

endmodule

bind txring_dma txring_checker #(
  .ADDR_W(ADDR_W), .MIN_FRAME(MIN_FRAME), .ACT_BIT(ACT_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .tcIrq(tcIrq), .memReq(memReq), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
  .byteValid(byteValid), .byteReady(byteReady), .byteData(byteData),
  .byteLast(byteLast)
);

// File: tb/sim_txring_dma.sv
module sim_txring_dma;

  localparam logic [31:0] BASE  = 32'h100;
  localparam logic [31:0] BUFB  = 32'h400;
  localparam logic [31:0] ACT   = 32'h8000_0000;
  localparam logic [31:0] ENDB  = 32'h4000_0000;
  localparam logic [31:0] ERRB  = 32'h0800_0000;

  logic clk, rstN, txDemand, tcClr, tcIrq;
  logic memReq, memWe, memAck;
  logic [31:0] ringBase, memAddr, memWdata, memRdata;
  logic byteValid, byteReady, byteLast, macErr;
  logic [7:0] byteData;

  txring_dma u0 (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .txDemand(txDemand),
    .tcClr(tcClr), .tcIrq(tcIrq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memAck(memAck),
    .memRdata(memRdata), .byteValid(byteValid), .byteReady(byteReady),
    .byteData(byteData), .byteLast(byteLast), .macErr(macErr)
  );

  logic [31:0] mem [1024];
  logic [31:0] origStat [4];
  int          planLen [4];
  logic        errPlan [8];
  logic [7:0]  capData [4096];
  logic        capLast [4096];
  int          capN, capFrames;
  logic [31:0] logAddr [256];
  logic        logWe [256];
  int          logN;
  int          errors, checks;
  int          waitLeft;

  task automatic chk(input logic ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] descAddrOf(input int d);
    return BASE + 32'(d * 16);
  endfunction

  function automatic logic [7:0] expByte(input int d, input int i);
    logic [31:0] w;
    if (i >= planLen[d]) return 8'h00;
    w = mem[(BUFB + 32'(d * 128) + 32'((i / 4) * 4)) >> 2];
    return 8'((w >> (24 - 8 * (i % 4))) & 32'hFF);
  endfunction

  function automatic logic [31:0] expStat(input logic [31:0] orig, input logic err);
    return (orig & ~(ACT | ERRB)) | (err ? ERRB : 32'h0);
  endfunction

  task automatic memModel();
    forever begin
      @(negedge clk);
      if (memAck) begin
        memAck = 1'b0;
        waitLeft = -1;
      end else if (memReq && rstN) begin
        if (waitLeft < 0) waitLeft = $urandom_range(0, 2);
        if (waitLeft == 0) begin
          memAck   = 1'b1;
          memRdata = mem[memAddr[11:2]];
          if (memWe) mem[memAddr[11:2]] = memWdata;
          if (logN < 256) begin
            logAddr[logN] = memAddr;
            logWe[logN]   = memWe;
          end
          logN++;
        end else begin
          waitLeft--;
        end
      end
    end
  endtask

  task automatic sinkModel();
    forever begin
      @(negedge clk);
      byteReady = ($urandom_range(0, 3) != 0);
      macErr    = errPlan[capFrames % 8];
      if (byteValid && byteReady && capN < 4096) begin
        capData[capN] = byteData;
        capLast[capN] = byteLast;
        capN++;
        if (byteLast) capFrames++;
      end
    end
  endtask

  task automatic watchdog();
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  endtask

  task automatic setDesc(input int d, input int len, input logic active);
    logic [31:0] st;
    st = 32'h0000_5A00 | 32'(d) | (d == 3 ? ENDB : 32'h0) |
         ($urandom_range(0, 1) != 0 ? ERRB : 32'h0) | (active ? ACT : 32'h0);
    origStat[d] = st;
    planLen[d]  = len;
    mem[descAddrOf(d) >> 2]       = st;
    mem[(descAddrOf(d) + 4) >> 2] = {16'(len), 16'hBEEF};
    mem[(descAddrOf(d) + 8) >> 2] = BUFB + 32'(d * 128);
    mem[(descAddrOf(d) + 12) >> 2] = 32'h0;
    for (int j = 0; j < 32; j++) mem[(BUFB + 32'(d * 128 + j * 4)) >> 2] = $urandom;
  endtask

  task automatic pulseDemand();
    @(negedge clk); txDemand = 1'b1;
    @(negedge clk); txDemand = 1'b0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    int guard = 0;
    while (quiet < 30 && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (memReq || byteValid) quiet = 0; else quiet++;
    end
    chk(guard < 20000, "R11", "run did not settle", guard, 0);
  endtask

  task automatic checkRun(input int start, input int k);
    int off = 0;
    int totSum = 0;
    chk(capFrames == k, "R11", "frames sent on one demand", capFrames, k);
    chk(logAddr[0] == descAddrOf(start), "R10", "first poll address", logAddr[0], descAddrOf(start));
    for (int f = 0; f < k; f++) begin
      int d = (start + f) % 4;
      int tot = planLen[d] < 64 ? 64 : planLen[d];
      int bad = 0;
      int badLast = 0;
      logic [7:0] firstAct = 0;
      logic [7:0] firstExp = 0;
      for (int i = 0; i < tot; i++) begin
        if (capData[off + i] !== expByte(d, i)) begin
          if (bad == 0) begin firstAct = capData[off + i]; firstExp = expByte(d, i); end
          bad++;
        end
        if (capLast[off + i] !== (i == tot - 1)) badLast++;
      end
      chk(bad == 0, planLen[d] < 64 ? "R6" : "R5", "frame bytes", firstAct, firstExp);
      chk(badLast == 0, planLen[d] < 64 ? "R6" : "R5", "last flag placement", badLast, 0);
      chk(mem[descAddrOf(d) >> 2] == expStat(origStat[d], errPlan[f]), "R8", "status writeback",
          mem[descAddrOf(d) >> 2], expStat(origStat[d], errPlan[f]));
      off += tot;
      totSum += tot;
    end
    chk(capN == totSum, "R5", "total bytes", capN, totSum);
    chk(logN >= 1 && !logWe[logN - 1] && logAddr[logN - 1] == descAddrOf((start + k) % 4),
        "R4", "stop on inactive descriptor", logAddr[logN - 1], descAddrOf((start + k) % 4));
    chk(tcIrq == 1'b1, "R9", "complete flag set", tcIrq, 1);
    @(negedge clk); tcClr = 1'b1;
    @(negedge clk); tcClr = 1'b0;
    chk(tcIrq == 1'b0, "R9", "complete flag cleared", tcIrq, 0);
  endtask

  task automatic runRound(input int start, input int k);
    for (int j = 0; j < 8; j++) errPlan[j] = ($urandom_range(0, 2) == 0);
    capN = 0; capFrames = 0; logN = 0;
    pulseDemand();
    waitIdle();
    checkRun(start, k);
  endtask

  initial begin
    int pos;
    clk = 0; rstN = 0; txDemand = 0; tcClr = 0; ringBase = BASE;
    memAck = 0; memRdata = 0; byteReady = 0; macErr = 0;
    errors = 0; checks = 0; capN = 0; capFrames = 0; logN = 0; waitLeft = -1;
    void'($urandom(32'd1977));
    for (int j = 0; j < 1024; j++) mem[j] = 32'h0;
    for (int j = 0; j < 8; j++) errPlan[j] = 1'b0;
    for (int d = 0; d < 4; d++) setDesc(d, 0, 1'b0);
    fork
      forever #4 clk = ~clk;
      memModel();
      sinkModel();
      watchdog();
    join_none

    repeat (3) @(negedge clk);
    chk(!memReq && !byteValid && !tcIrq, "R1", "outputs in reset",
        {memReq, byteValid, tcIrq}, 0);
    rstN = 1;
    @(negedge clk);
    chk(!memReq && !byteValid && !tcIrq, "R1", "outputs after reset",
        {memReq, byteValid, tcIrq}, 0);
    repeat (20) @(negedge clk);
    chk(logN == 0, "R2", "no access without demand", logN, 0);

    // Directed: multi-word odd length, short pad, zero length (R5 R6 R3)
    setDesc(0, 70, 1'b1); setDesc(1, 10, 1'b1); setDesc(2, 0, 1'b1); setDesc(3, 0, 1'b0);
    for (int j = 0; j < 8; j++) errPlan[j] = (j == 1);
    capN = 0; capFrames = 0; logN = 0;
    pulseDemand();
    waitIdle();
    chk(logAddr[1] == BASE + 4 && logAddr[2] == BASE + 8, "R3", "descriptor word order",
        {logAddr[1], logAddr[2]}, {BASE + 4, BASE + 8});
    checkRun(0, 3);

    // Directed: exactly minimum length on the ring-end descriptor, then wrap (R10)
    setDesc(3, 64, 1'b1);
    runRound(3, 1);
    pos = 0;

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      int k = $urandom_range(1, 3);
      for (int j = 0; j < k; j++) setDesc((pos + j) % 4, $urandom_range(0, 100), 1'b1);
      setDesc((pos + k) % 4, 5, 1'b0);
      runRound(pos, k);
      pos = (pos + k) % 4;
    end

    // Demand while busy: one extra poll of the stopping descriptor (R12)
    setDesc(pos, 90, 1'b1);
    setDesc((pos + 1) % 4, 5, 1'b0);
    for (int j = 0; j < 8; j++) errPlan[j] = 1'b0;
    capN = 0; capFrames = 0; logN = 0;
    pulseDemand();
    while (!byteValid) @(negedge clk);
    pulseDemand();
    waitIdle();
    begin
      int polls = 0;
      for (int j = 0; j < logN && j < 256; j++)
        if (!logWe[j] && logAddr[j] == descAddrOf((pos + 1) % 4)) polls++;
      chk(polls == 2, "R12", "extra poll after busy demand", polls, 2);
    end
    chk(capFrames == 1, "R12", "frames on busy demand run", capFrames, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule